// File: doc/BRIEF.md
# Debug Command Decoder with Status and Trace Counter

This block sits behind a debug access port and turns each 8-bit debug command into register strobes and execution requests. A command word arrives in parallel with a one-cycle command strobe. A write command is followed by a separate data-update strobe that carries the 24-bit value. The block raises a one-hot read strobe or write strobe for the selected debug register. It also decides whether the command asks the core to execute the held instruction once, or to resume normal running.

Two registers live inside the block. The first is the status/control word: trace enable, an interrupt-instead-of-debug select, three read-only entry-cause flags and a two-bit core state field. The second is a 16-bit trace counter that steps the core through a programmed number of instructions. It then requests debug entry, or an interrupt when that mode is selected. Every other register is outside the block. Their read values come in on `ext_rd_data`, and they are written from `upd_data` when their write strobe fires.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: Command bit 7 = 1 means read, bit 6 = GO, bit 5 = EX and bits 4:0 = register select. A read command with a defined select raises `rd_stb[select]` in its own strobe cycle. Defined selects are 0,1,2,5,6,9,10,11,12,13,15,16,17,18. Select 31 means "no register", and every other code is reserved. Reserved codes and 31 raise no strobe.
- R2: A write command with a defined select raises `wr_stb[select]` in the cycle of the next `upd_valid`. A write to a reserved code or to 31 writes nothing. An `upd_valid` with no pending write does nothing. A new command discards a pending write.
- R3: GO is honoured only for a write to select 10, where it fires with that write's data update, or for a read or write to select 31, where it fires on the command strobe. In every other case GO is ignored.
- R4: An honoured GO with EX = 0 pulses `go_step`, and with EX = 1 pulses `go_resume`. EX without an honoured GO does nothing.
- R5: In the status word, bit 0 (trace enable) and bit 1 (interrupt select) are writable through select 0. Bits 4:2 and 7:6 ignore writes. Bit 5 and bits 23:8 read 0.
- R6: Status bits 7:6 read 11 while `core_debug` is high. Otherwise they read 01 while `core_wait_stop` is high, 10 while `core_bus_wait` is high, and 00 when none of these is high. They follow that priority order.
- R7: Cause flags are bit 2 (software debug, set by `sw_dbg_hit`), bit 3 (breakpoint, set by `bkpt_hit`) and bit 4 (trace entry). They clear in the cycle after `core_debug` falls. Reset clears the whole status word.
- R8: The trace counter is written through select 13 from `upd_data[15:0]` and reads back in `rd_data[15:0]`. When trace is enabled, it decrements once for each executed instruction that is above 0.
- R9: When trace is enabled and an instruction executes with the counter at 0, `trace_dbg_req` pulses in the next cycle and bit 4 sets. If the interrupt select is on, `trace_irq_req` pulses instead and bit 4 stays clear.
- R10: An instruction with `core_abort` high neither decrements the counter nor produces a trace request.
- R11: When a counter write and an executed instruction fall in the same cycle, the written value is kept.
- R12: `rd_data` is loaded at the edge that ends a read command. Status and trace selects return internal values. Other defined selects return `ext_rd_data`. Reserved selects and 31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_word | input | 8 | Command word |
| upd_valid | input | 1 | Data-update strobe for a pending write |
| upd_data | input | 24 | Write data |
| ext_rd_data | input | 24 | Read value of the external register selected by `rd_stb` |
| rd_stb | output | 32 | One-hot read strobe by select code |
| wr_stb | output | 32 | One-hot write strobe by select code |
| rd_data | output | 24 | Registered read result |
| go_step | output | 1 | Execute held instruction, then return to debug |
| go_resume | output | 1 | Execute held instruction and resume running |
| core_debug | input | 1 | Core is in debug mode |
| core_wait_stop | input | 1 | Core is in wait or stop |
| core_bus_wait | input | 1 | Core is waiting for the bus |
| core_exec | input | 1 | An instruction completed this cycle |
| core_abort | input | 1 | The instruction of this cycle was aborted |
| sw_dbg_hit | input | 1 | Debug entry caused by a software debug instruction |
| bkpt_hit | input | 1 | Debug entry caused by a memory breakpoint |
| trace_dbg_req | output | 1 | Trace expiry requests debug entry |
| trace_irq_req | output | 1 | Trace expiry requests an interrupt |

## Verification
Two events can land in the same cycle: a data update that writes the trace counter, and an executed instruction that would decrement it. The bench loads a known count, then asserts `core_exec` in exactly the cycle of the counter's data update. It then reads the counter back and expects the written value, not that value minus one. A second collision, a cause flag arriving in the cycle debug mode is left, is excluded from the clear-on-exit assertion and resolved in favour of the set.

// File: rtl/dbg_cmd_pkg.sv
// Shared constants and command layout for the debug command decoder.
// Assumes a 5-bit select space of 32 codes; encodings are fixed by the
// command format and are not parameters.
package dbg_cmd_pkg;
    localparam int SEL_W = 5;
    localparam int NSEL  = 1 << SEL_W;

    localparam logic [SEL_W-1:0] SEL_STATUS = 5'h00;
    localparam logic [SEL_W-1:0] SEL_PDB    = 5'h0A;
    localparam logic [SEL_W-1:0] SEL_TRACE  = 5'h0D;
    localparam logic [SEL_W-1:0] SEL_NONE   = 5'h1F;

    // Codes that name a register: 0,1,2,5,6,9..13,15..18
    localparam logic [NSEL-1:0] DEFINED_MASK = 32'h0007_BE67;

    typedef struct packed {
        logic             rd;
        logic             go;
        logic             ex;
        logic [SEL_W-1:0] sel;
    } cmd_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
// Command decoder: turns command/update strobes into one-hot register
// strobes and GO/EX requests. Assumes cmd_valid and upd_valid are single
// cycle pulses; a command in the same cycle as an update wins.
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_word,
    input  logic            upd_valid,
    output logic [NSEL-1:0] rd_stb,
    output logic [NSEL-1:0] wr_stb,
    output logic            go_step,
    output logic            go_resume
);
    cmd_t             cmd;
    logic             defined;
    logic             pend_q;
    logic             pend_go_q;
    logic             pend_ex_q;
    logic [SEL_W-1:0] pend_sel_q;
    logic             upd_fire;
    logic             go_cmd;
    logic             go_upd;

    assign cmd      = cmd_t'(cmd_word);
    assign defined  = DEFINED_MASK[cmd.sel];
    assign upd_fire = upd_valid && pend_q && !cmd_valid;
    assign go_cmd   = cmd_valid && cmd.go && (cmd.sel == SEL_NONE);
    assign go_upd   = upd_fire && pend_go_q;

    // Track a write command waiting for its data update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_go_q  <= 1'b0;
            pend_ex_q  <= 1'b0;
            pend_sel_q <= '0;
        end else if (cmd_valid) begin
            pend_q     <= !cmd.rd && defined;
            pend_go_q  <= cmd.go && !cmd.rd && (cmd.sel == SEL_PDB);
            pend_ex_q  <= cmd.ex;
            pend_sel_q <= cmd.sel;
        end else if (upd_valid) begin
            pend_q <= 1'b0;
        end
    end

    // One-hot read and write strobes
    always_comb begin
        rd_stb = '0;
        wr_stb = '0;
        if (cmd_valid && cmd.rd && defined) rd_stb[cmd.sel] = 1'b1;
        if (upd_fire) wr_stb[pend_sel_q] = 1'b1;
    end

    // GO/EX resolution
    always_comb begin
        go_step   = 1'b0;
        go_resume = 1'b0;
        if (go_cmd) begin
            go_step   = !cmd.ex;
            go_resume = cmd.ex;
        end else if (go_upd) begin
            go_step   = !pend_ex_q;
            go_resume = pend_ex_q;
        end
    end
endmodule

// File: rtl/dbg_status_reg.sv
// Status/control word: two writable control bits, three entry-cause flags
// that clear on leaving debug mode, and a live core state field.
// Assumes cause inputs are pulses; a set beats a clear in the same cycle.
module dbg_status_reg #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_ctl,
    input  logic              core_debug,
    input  logic              core_wait_stop,
    input  logic              core_bus_wait,
    input  logic              sw_dbg_hit,
    input  logic              bkpt_hit,
    input  logic              trace_hit,
    output logic              tme,
    output logic              ime,
    output logic [DATA_W-1:0] sts_word
);
    localparam int PAD_W = DATA_W - 8;

    logic       dbg_q;
    logic       leaving;
    logic [2:0] cause_q;
    logic [2:0] cause_set;
    logic [1:0] os;

    assign leaving   = dbg_q && !core_debug;
    assign cause_set = {trace_hit, bkpt_hit, sw_dbg_hit};

    // Control bits and debug-mode history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tme   <= 1'b0;
            ime   <= 1'b0;
            dbg_q <= 1'b0;
        end else begin
            dbg_q <= core_debug;
            if (wr_en) {ime, tme} <= wr_ctl;
        end
    end

    // Cause flags: set per cause, cleared together on exit
    always_ff @(posedge clk) begin
        if (!rst_n)       cause_q <= '0;
        else if (leaving) cause_q <= cause_set;
        else              cause_q <= cause_q | cause_set;
    end

    // Core state with debug > wait/stop > bus wait priority
    always_comb begin
        if (core_debug)          os = 2'b11;
        else if (core_wait_stop) os = 2'b01;
        else if (core_bus_wait)  os = 2'b10;
        else                     os = 2'b00;
    end

    assign sts_word = {{PAD_W{1'b0}}, os, 1'b0, cause_q, ime, tme};
endmodule

// File: rtl/dbg_trace_ctr.sv
// Instruction-step trace counter. Decrements per executed, non-aborted
// instruction while tracing; an execution at zero raises a registered
// debug or interrupt request. A write in the same cycle wins.
module dbg_trace_ctr #(
    parameter int TRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TRC_W-1:0] wr_val,
    input  logic             tme,
    input  logic             ime,
    input  logic             core_exec,
    input  logic             core_abort,
    output logic [TRC_W-1:0] cnt,
    output logic             hit_dbg,
    output logic             trace_dbg_req,
    output logic             trace_irq_req
);
    logic run;
    logic hit;

    assign run     = core_exec && !core_abort && tme;
    assign hit     = run && (cnt == '0);
    assign hit_dbg = hit && !ime;

    // Counter load and step
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (wr_en)               cnt <= wr_val;
        else if (run && cnt != '0)    cnt <= cnt - 1'b1;
    end

    // Registered expiry requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_dbg_req <= 1'b0;
            trace_irq_req <= 1'b0;
        end else begin
            trace_dbg_req <= hit && !ime;
            trace_irq_req <= hit && ime;
        end
    end
endmodule

// File: rtl/dbg_cmd_ctrl.sv
// Top of the debug command decoder: joins the decoder, status word and
// trace counter, and registers read results. External registers answer
// their rd_stb combinationally on ext_rd_data in the same cycle.
module dbg_cmd_ctrl
    import dbg_cmd_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int TRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_word,
    input  logic              upd_valid,
    input  logic [DATA_W-1:0] upd_data,
    input  logic [DATA_W-1:0] ext_rd_data,
    output logic [NSEL-1:0]   rd_stb,
    output logic [NSEL-1:0]   wr_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              go_step,
    output logic              go_resume,
    input  logic              core_debug,
    input  logic              core_wait_stop,
    input  logic              core_bus_wait,
    input  logic              core_exec,
    input  logic              core_abort,
    input  logic              sw_dbg_hit,
    input  logic              bkpt_hit,
    output logic              trace_dbg_req,
    output logic              trace_irq_req
);
    localparam int CNT_PAD = DATA_W - TRC_W;

    cmd_t               cmd;
    logic               tme;
    logic               ime;
    logic               hit_dbg;
    logic [TRC_W-1:0]   trc_cnt;
    logic [DATA_W-1:0]  sts_word;
    logic [DATA_W-1:0]  rd_mux;

    assign cmd = cmd_t'(cmd_word);

    dbg_cmd_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .upd_valid (upd_valid),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .go_step   (go_step),
        .go_resume (go_resume)
    );

    dbg_status_reg #(.DATA_W(DATA_W)) u_sts (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_stb[SEL_STATUS]),
        .wr_ctl         (upd_data[1:0]),
        .core_debug     (core_debug),
        .core_wait_stop (core_wait_stop),
        .core_bus_wait  (core_bus_wait),
        .sw_dbg_hit     (sw_dbg_hit),
        .bkpt_hit       (bkpt_hit),
        .trace_hit      (hit_dbg),
        .tme            (tme),
        .ime            (ime),
        .sts_word       (sts_word)
    );

    dbg_trace_ctr #(.TRC_W(TRC_W)) u_trc (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_stb[SEL_TRACE]),
        .wr_val        (upd_data[TRC_W-1:0]),
        .tme           (tme),
        .ime           (ime),
        .core_exec     (core_exec),
        .core_abort    (core_abort),
        .cnt           (trc_cnt),
        .hit_dbg       (hit_dbg),
        .trace_dbg_req (trace_dbg_req),
        .trace_irq_req (trace_irq_req)
    );

    // Select the read source for the current command
    always_comb begin
        if (cmd.sel == SEL_STATUS)      rd_mux = sts_word;
        else if (cmd.sel == SEL_TRACE)  rd_mux = {{CNT_PAD{1'b0}}, trc_cnt};
        else if (DEFINED_MASK[cmd.sel]) rd_mux = ext_rd_data;
        else                            rd_mux = '0;
    end

    // Capture read data at the end of a read command
    always_ff @(posedge clk) begin
        if (!rst_n)                    rd_data <= '0;
        else if (cmd_valid && cmd.rd)  rd_data <= rd_mux;
    end
endmodule

// File: rtl/dbg_cmd_chk.sv
// Property checker for dbg_cmd_ctrl, attached by bind below.
module dbg_cmd_chk
    import dbg_cmd_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSEL-1:0]   rd_stb,
    input logic [NSEL-1:0]   wr_stb,
    input logic              go_step,
    input logic              go_resume,
    input logic              trace_dbg_req,
    input logic              trace_irq_req,
    input logic              core_debug,
    input logic              core_exec,
    input logic              core_abort,
    input logic              sw_dbg_hit,
    input logic              bkpt_hit,
    input logic [DATA_W-1:0] sts_word
);
    // R1: at most one read strobe
    p_rd_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_stb));
    // R2: at most one write strobe
    p_wr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));
    // R1: reserved codes never strobed for read
    p_rd_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb & ~DEFINED_MASK) == '0);
    // R2: reserved codes never strobed for write
    p_wr_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb & ~DEFINED_MASK) == '0);
    // R4: step and resume are exclusive
    p_go_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_step && go_resume));
    // R9: debug and interrupt requests are exclusive
    p_req_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(trace_dbg_req && trace_irq_req));
    // R10: an aborted instruction produces no request
    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_exec && core_abort) |=> !(trace_dbg_req || trace_irq_req));
    // R7: leaving debug with no new cause clears all cause flags
    p_exit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_debug) && !sw_dbg_hit && !bkpt_hit && !core_exec)
        |=> (sts_word[4:2] == 3'b000));
    // R5: reserved status bits read zero
    p_sts_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_word[DATA_W-1:8] == '0) && !sts_word[5]);
endmodule

bind dbg_cmd_ctrl dbg_cmd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_stb        (rd_stb),
    .wr_stb        (wr_stb),
    .go_step       (go_step),
    .go_resume     (go_resume),
    .trace_dbg_req (trace_dbg_req),
    .trace_irq_req (trace_irq_req),
    .core_debug    (core_debug),
    .core_exec     (core_exec),
    .core_abort    (core_abort),
    .sw_dbg_hit    (sw_dbg_hit),
    .bkpt_hit      (bkpt_hit),
    .sts_word      (sts_word)
);

// File: tb/tb_dbg_cmd_ctrl.sv
// Directed bench: one task per scenario, inputs driven on the falling
// edge, outputs sampled before the next rising edge.
module tb_dbg_cmd_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_word = '0;
    logic        upd_valid = 1'b0;
    logic [23:0] upd_data = '0;
    logic [23:0] ext_rd_data = 24'hABCDEF;
    logic [31:0] rd_stb, wr_stb;
    logic [23:0] rd_data;
    logic        go_step, go_resume;
    logic        core_debug = 1'b0, core_wait_stop = 1'b0, core_bus_wait = 1'b0;
    logic        core_exec = 1'b0, core_abort = 1'b0;
    logic        sw_dbg_hit = 1'b0, bkpt_hit = 1'b0;
    logic        trace_dbg_req, trace_irq_req;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] c_rs, c_ws;
    logic        c_gs, c_gr;
    logic [23:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .upd_valid(upd_valid), .upd_data(upd_data), .ext_rd_data(ext_rd_data),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .rd_data(rd_data),
        .go_step(go_step), .go_resume(go_resume),
        .core_debug(core_debug), .core_wait_stop(core_wait_stop),
        .core_bus_wait(core_bus_wait), .core_exec(core_exec),
        .core_abort(core_abort), .sw_dbg_hit(sw_dbg_hit), .bkpt_hit(bkpt_hit),
        .trace_dbg_req(trace_dbg_req), .trace_irq_req(trace_irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Command strobe; captures combinational outputs of that cycle
    task automatic send_cmd(input logic [7:0] w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = w;
        #1;
        c_rs = rd_stb; c_ws = wr_stb; c_gs = go_step; c_gr = go_resume;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_upd(input logic [23:0] d);
        @(negedge clk);
        upd_valid = 1'b1; upd_data = d;
        #1;
        c_rs = rd_stb; c_ws = wr_stb; c_gs = go_step; c_gr = go_resume;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] sel, output logic [23:0] val);
        send_cmd({3'b100, sel});
        val = rd_data;
    endtask

    task automatic write_reg(input logic [4:0] sel, input logic [23:0] d);
        send_cmd({3'b000, sel});
        send_upd(d);
    endtask

    // One executed instruction; returns requests seen one cycle later
    task automatic exec_one(input logic abort, output logic dreq, output logic ireq);
        @(negedge clk);
        core_exec = 1'b1; core_abort = abort;
        @(negedge clk);
        core_exec = 1'b0; core_abort = 1'b0;
        dreq = trace_dbg_req; ireq = trace_irq_req;
    endtask

    task automatic t_reset;
        check("R7 reset status", {8'h0, rd_data}, 32'h0);
        read_reg(5'h00, v); check("R7 status after reset", {8'h0, v}, 32'h0);
        read_reg(5'h0D, v); check("R8 counter after reset", {8'h0, v}, 32'h0);
        check("R9 no request after reset", {30'h0, trace_dbg_req, trace_irq_req}, 32'h0);
    endtask

    task automatic t_strobes;
        send_cmd(8'h81);
        check("R1 read strobe code 1", c_rs, 32'h0000_0002);
        check("R12 external read data", {8'h0, rd_data}, 32'h00ABCDEF);
        send_cmd(8'h92);
        check("R1 read strobe code 18", c_rs, 32'h0004_0000);
        send_cmd(8'h83);
        check("R1 reserved read no strobe", c_rs, 32'h0);
        check("R12 reserved read zero", {8'h0, rd_data}, 32'h0);
        send_cmd(8'h9F);
        check("R1 no-register read no strobe", c_rs, 32'h0);
        send_cmd(8'h05);
        check("R2 no write on command", c_ws, 32'h0);
        send_upd(24'h123456);
        check("R2 write strobe code 5", c_ws, 32'h0000_0020);
        send_upd(24'h000111);
        check("R2 update without pending", c_ws, 32'h0);
        send_cmd(8'h03); send_upd(24'h1);
        check("R2 reserved write none", c_ws, 32'h0);
        send_cmd(8'h06); send_cmd(8'h81); send_upd(24'h2);
        check("R2 pending discarded by new command", c_ws, 32'h0);
    endtask

    task automatic t_go;
        send_cmd(8'h5F);
        check("R3 GO on no-register write", {30'h0, c_gs, c_gr}, 32'h2);
        send_cmd(8'hDF);
        check("R3 GO on no-register read", {30'h0, c_gs, c_gr}, 32'h2);
        send_cmd(8'h7F);
        check("R4 GO+EX resumes", {30'h0, c_gs, c_gr}, 32'h1);
        send_cmd(8'h3F);
        check("R4 EX alone ignored", {30'h0, c_gs, c_gr}, 32'h0);
        send_cmd(8'h4A);
        check("R3 GO on PDB waits for data", {30'h0, c_gs, c_gr}, 32'h0);
        send_upd(24'h0);
        check("R3 GO on PDB update", {30'h0, c_gs, c_gr}, 32'h2);
        check("R2 PDB write strobe", c_ws, 32'h0000_0400);
        send_cmd(8'h6A); send_upd(24'h0);
        check("R4 GO+EX on PDB update", {30'h0, c_gs, c_gr}, 32'h1);
        send_cmd(8'h41);
        check("R3 GO ignored at command", {30'h0, c_gs, c_gr}, 32'h0);
        send_upd(24'h0);
        check("R3 GO ignored on other register", {30'h0, c_gs, c_gr}, 32'h0);
        send_cmd(8'hCA);
        check("R3 GO ignored on PDB read", {30'h0, c_gs, c_gr}, 32'h0);
    endtask

    task automatic t_status_bits;
        write_reg(5'h00, 24'hFFFFFF);
        read_reg(5'h00, v);
        check("R5 status write mask", {8'h0, v}, 32'h3);
        write_reg(5'h00, 24'h0);
        core_wait_stop = 1'b1;
        read_reg(5'h00, v); check("R6 wait/stop state", {30'h0, v[7:6]}, 32'h1);
        core_bus_wait = 1'b1;
        read_reg(5'h00, v); check("R6 wait/stop over bus wait", {30'h0, v[7:6]}, 32'h1);
        core_wait_stop = 1'b0;
        read_reg(5'h00, v); check("R6 bus wait state", {30'h0, v[7:6]}, 32'h2);
        core_debug = 1'b1;
        read_reg(5'h00, v); check("R6 debug state", {30'h0, v[7:6]}, 32'h3);
        core_debug = 1'b0; core_bus_wait = 1'b0;
        read_reg(5'h00, v); check("R6 executing state", {30'h0, v[7:6]}, 32'h0);
    endtask

    task automatic t_trace;
        logic d, i;
        write_reg(5'h00, 24'h1);
        write_reg(5'h0D, 24'h000002);
        exec_one(1'b0, d, i);
        check("R9 no request above zero", {30'h0, d, i}, 32'h0);
        read_reg(5'h0D, v); check("R8 decrement to 1", {8'h0, v}, 32'h1);
        exec_one(1'b0, d, i);
        read_reg(5'h0D, v); check("R8 decrement to 0", {8'h0, v}, 32'h0);
        exec_one(1'b0, d, i);
        check("R9 debug request at zero", {30'h0, d, i}, 32'h2);
        read_reg(5'h00, v); check("R9 trace flag set", {8'h0, v}, 32'h11);
        core_debug = 1'b1;
        read_reg(5'h00, v); check("R7 flag held in debug", {8'h0, v}, 32'hD1);
        core_debug = 1'b0;
        read_reg(5'h00, v); check("R7 flags clear on exit", {8'h0, v}, 32'h01);
        write_reg(5'h00, 24'h3);
        exec_one(1'b0, d, i);
        check("R9 interrupt request", {30'h0, d, i}, 32'h1);
        read_reg(5'h00, v); check("R9 no flag in interrupt mode", {8'h0, v}, 32'h03);
    endtask

    task automatic t_abort_and_collision;
        logic d, i;
        write_reg(5'h00, 24'h1);
        write_reg(5'h0D, 24'h000001);
        exec_one(1'b1, d, i);
        read_reg(5'h0D, v); check("R10 abort keeps counter", {8'h0, v}, 32'h1);
        write_reg(5'h0D, 24'h0);
        exec_one(1'b1, d, i);
        check("R10 abort at zero no request", {30'h0, d, i}, 32'h0);
        write_reg(5'h0D, 24'h000004);
        send_cmd(8'h0D);
        @(negedge clk);
        upd_valid = 1'b1; upd_data = 24'h000009; core_exec = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0; core_exec = 1'b0;
        read_reg(5'h0D, v); check("R11 write beats decrement", {8'h0, v}, 32'h9);
        write_reg(5'h00, 24'h0);
        exec_one(1'b0, d, i);
        read_reg(5'h0D, v); check("R8 no decrement when disabled", {8'h0, v}, 32'h9);
    endtask

    task automatic t_causes;
        @(negedge clk); sw_dbg_hit = 1'b1;
        @(negedge clk); sw_dbg_hit = 1'b0;
        read_reg(5'h00, v); check("R7 software cause", {8'h0, v}, 32'h04);
        @(negedge clk); bkpt_hit = 1'b1;
        @(negedge clk); bkpt_hit = 1'b0;
        read_reg(5'h00, v); check("R7 breakpoint cause", {8'h0, v}, 32'h0C);
        write_reg(5'h00, 24'hFFFF1C);
        read_reg(5'h00, v); check("R5 cause bits ignore writes", {8'h0, v}, 32'h0C);
        core_debug = 1'b1; @(negedge clk); core_debug = 1'b0;
        read_reg(5'h00, v); check("R7 causes cleared", {8'h0, v}, 32'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_strobes;
        t_go;
        t_status_bits;
        t_trace;
        t_abort_and_collision;
        t_causes;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule